// File: doc/BRIEF.md
# DDR Controller Operating-State Sequencer

This block holds the operating state of a DDR memory controller. Software steers it by writing a request code. It observes the result through a 3-bit status value. The block moves between four settled states: init, config, access and low-power. Every accepted move first enters a transient request state. That state is shown on the status output until the rest of the controller finishes its handshake. It is left when a ready input is seen or when a fixed number of cycles has passed, whichever comes first.

Low-power can only be left through a wakeup, and a wakeup always lands in access. To reach config from low-power, software must first send a wakeup and then a config request. A request that does not apply to the current state is dropped without effect. This includes any request that arrives while a transition is still in flight.

Top module: `mc_opstate_ctrl`

## Requirements
- R1: After reset the status output reads 0 (init).
- R2: A config request (code 1) seen in init (0) or access (3) moves the status to config-request (2), and then to config (1).
- R3: A go request (code 2) seen in config (1) moves the status to access-request (4), and then to access (3).
- R4: A sleep request (code 3) is accepted only in access (3). It moves the status to low-power-entry-request (6), and then to low-power (5).
- R5: A wakeup request (code 4) seen in low-power (5) moves the status to low-power-exit-request (7), and then to access (3). A config request seen in low-power is ignored.
- R6: While `hs_ready` stays low, each transient state (2, 4, 6, 7) is shown for exactly DWELL cycles before the target state appears.
- R7: With USE_HS set, a cycle in a transient state that has `hs_ready` high is the last cycle of that state.
- R8: A request with no entry above for the current state is ignored and the status does not change. This covers code 0 (init), codes 5 to 7, and any request made during a transient state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Request write strobe, one cycle per request |
| req_code | input | 3 | Request code: 0 init, 1 config, 2 go, 3 sleep, 4 wakeup |
| hs_ready | input | 1 | Handshake from the DRAM side that ends a transient state early |
| stat_o | output | 3 | Status: 0 init, 1 config, 2 config-req, 3 access, 4 access-req, 5 low-power, 6 lp-entry-req, 7 lp-exit-req |

## Verification
The assertions check the following on every cycle:
- Each settled state is entered only from its own request state.
- Low-power is left only toward the exit-request state.
- A transient state never outlasts DWELL cycles, and it ends at once when the handshake is seen.
- A settled state holds when no request is written.

Only the bench scenarios can show which state a given request reaches. They also show that requests outside the legal pairs are dropped and that the dwell is exactly DWELL cycles. The bench sweeps every request code from every settled state to show these.

// File: rtl/mc_opstate_pkg.sv
package mc_opstate_pkg;

   typedef enum logic [2:0] {
      ST_INIT    = 3'd0,
      ST_CFG     = 3'd1,
      ST_CFG_REQ = 3'd2,
      ST_ACC     = 3'd3,
      ST_ACC_REQ = 3'd4,
      ST_LP      = 3'd5,
      ST_LP_IN   = 3'd6,
      ST_LP_OUT  = 3'd7
   } opstate_e;

   localparam logic [2:0] RQ_INIT  = 3'd0;
   localparam logic [2:0] RQ_CFG   = 3'd1;
   localparam logic [2:0] RQ_GO    = 3'd2;
   localparam logic [2:0] RQ_SLEEP = 3'd3;
   localparam logic [2:0] RQ_WAKE  = 3'd4;

   function automatic logic is_transient(logic [2:0] s);
      return (s == ST_CFG_REQ) || (s == ST_ACC_REQ) ||
             (s == ST_LP_IN)   || (s == ST_LP_OUT);
   endfunction

   // settled state that a transient state resolves into
   function automatic opstate_e settle_target(opstate_e s);
      case (s)
         ST_CFG_REQ: return ST_CFG;
         ST_ACC_REQ: return ST_ACC;
         ST_LP_IN:   return ST_LP;
         ST_LP_OUT:  return ST_ACC;
         default:    return s;
      endcase
   endfunction

endpackage

// File: rtl/mc_opstate_decode.sv
module mc_opstate_decode
   import mc_opstate_pkg::*;
(
   input  opstate_e   cur_st,
   input  logic       req_vld,
   input  logic [2:0] req_code,
   output logic       accept,
   output opstate_e   pend_st
);

   always_comb begin
      accept  = 1'b0;
      pend_st = cur_st;
      if (req_vld) begin
         unique case (cur_st)
            ST_INIT: if (req_code == RQ_CFG) begin
               accept  = 1'b1;
               pend_st = ST_CFG_REQ;
            end
            ST_CFG: if (req_code == RQ_GO) begin
               accept  = 1'b1;
               pend_st = ST_ACC_REQ;
            end
            ST_ACC: begin
               if (req_code == RQ_CFG) begin
                  accept  = 1'b1;
                  pend_st = ST_CFG_REQ;
               end else if (req_code == RQ_SLEEP) begin
                  accept  = 1'b1;
                  pend_st = ST_LP_IN;
               end
            end
            ST_LP: if (req_code == RQ_WAKE) begin
               accept  = 1'b1;
               pend_st = ST_LP_OUT;
            end
            default: ; // transient states drop every request
         endcase
      end
   end

endmodule

// File: rtl/mc_opstate_dwell.sv
module mc_opstate_dwell #(
   parameter int DWELL  = 4,
   parameter bit USE_HS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic active,
   input  logic hs_ready,
   output logic done
);

   localparam int CW = (DWELL > 1) ? $clog2(DWELL) : 1;
   localparam logic [CW-1:0] LAST = CW'(DWELL - 1);

   initial begin
      if (DWELL < 1) $error("mc_opstate_dwell: DWELL must be at least 1");
   end

   logic [CW-1:0] cnt;
   logic          at_last;

   assign at_last = (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (start)  cnt <= '0;
      else if (active) cnt <= cnt + 1'b1;
   end

   generate
      if (USE_HS) begin : g_hs
         assign done = active && (hs_ready || at_last);
      end else begin : g_timer
         logic unused_hs;
         assign unused_hs = hs_ready;
         assign done = active && at_last;
      end
   endgenerate

endmodule

// File: rtl/mc_opstate_ctrl.sv
module mc_opstate_ctrl
   import mc_opstate_pkg::*;
#(
   parameter int DWELL  = 4,
   parameter bit USE_HS = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_vld,
   input  logic [2:0] req_code,
   input  logic       hs_ready,
   output logic [2:0] stat_o
);

   opstate_e st, pend_st;
   logic     accept, in_flight, settle;

   assign in_flight = is_transient(st);

   mc_opstate_decode u_dec (
      .cur_st  (st),
      .req_vld (req_vld),
      .req_code(req_code),
      .accept  (accept),
      .pend_st (pend_st)
   );

   mc_opstate_dwell #(.DWELL(DWELL), .USE_HS(USE_HS)) u_dwell (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (accept),
      .active  (in_flight),
      .hs_ready(hs_ready),
      .done    (settle)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      st <= ST_INIT;
      else if (accept) st <= pend_st;
      else if (settle) st <= settle_target(st);
   end

   assign stat_o = st;

endmodule

// File: rtl/mc_opstate_chk.sv
module mc_opstate_chk
   import mc_opstate_pkg::*;
#(
   parameter int DWELL  = 4,
   parameter bit USE_HS = 1'b1
) (
   input logic       clk,
   input logic       rst_n,
   input logic       req_vld,
   input logic       hs_ready,
   input logic [2:0] stat
);

   int tcnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                tcnt <= 0;
      else if (is_transient(stat)) tcnt <= tcnt + 1;
      else                       tcnt <= 0;
   end

   p_cfg_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (stat == 3'd1 && $past(stat) != 3'd1) |-> $past(stat) == 3'd2);

   p_acc_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (stat == 3'd3 && $past(stat) != 3'd3) |-> ($past(stat) == 3'd4 || $past(stat) == 3'd7));

   p_lp_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (stat == 3'd5 && $past(stat) != 3'd5) |-> $past(stat) == 3'd6);

   p_lp_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(stat) == 3'd5 && stat != 3'd5) |-> stat == 3'd7);

   p_dwell_max_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (is_transient(stat) && tcnt == DWELL - 1) |=> !is_transient(stat));

   p_hs_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (USE_HS && is_transient(stat) && hs_ready) |=> !is_transient(stat));

   p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!is_transient(stat) && !req_vld) |=> $stable(stat));

endmodule

bind mc_opstate_ctrl mc_opstate_chk #(.DWELL(DWELL), .USE_HS(USE_HS)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .req_vld (req_vld),
   .hs_ready(hs_ready),
   .stat    (stat_o)
);

// File: tb/mc_opstate_ctrl_test.sv
module mc_opstate_ctrl_test;

   localparam int DWELL = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_vld = 1'b0;
   logic [2:0] req_code = 3'd0;
   logic       hs = 1'b0;
   logic [2:0] stat;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   mc_opstate_ctrl #(.DWELL(DWELL), .USE_HS(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_code(req_code),
      .hs_ready(hs), .stat_o(stat)
   );

   task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: stat=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // request model from the requirements
   function automatic logic [2:0] model_pend(logic [2:0] s, logic [2:0] c);
      if ((s == 0 || s == 3) && c == 1) return 3'd2;
      if (s == 1 && c == 2) return 3'd4;
      if (s == 3 && c == 3) return 3'd6;
      if (s == 5 && c == 4) return 3'd7;
      return s;
   endfunction

   function automatic logic [2:0] model_final(logic [2:0] p);
      case (p)
         3'd2: return 3'd1;
         3'd4: return 3'd3;
         3'd6: return 3'd5;
         3'd7: return 3'd3;
         default: return p;
      endcase
   endfunction

   function automatic string tag_of(logic [2:0] s, logic [2:0] c);
      if (model_pend(s, c) == s) return "R8";
      case (c)
         3'd1: return "R2";
         3'd2: return "R3";
         3'd3: return "R4";
         default: return "R5";
      endcase
   endfunction

   task automatic send(input logic [2:0] c);
      @(negedge clk);
      req_vld = 1'b1; req_code = c;
      @(negedge clk);
      req_vld = 1'b0;
   endtask

   task automatic settle();
      repeat (DWELL) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); @(negedge clk); rst_n = 1'b1;
      chk("R1", stat, 3'd0);
   endtask

   task automatic go_to(input logic [2:0] s);
      do_reset();
      if (s != 0) begin send(3'd1); settle(); end
      if (s == 3 || s == 5) begin send(3'd2); settle(); end
      if (s == 5) begin send(3'd3); settle(); end
      chk("R8", stat, s);
   endtask

   initial begin
      #2_000_000;
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog: stat=%0d expected=done", stat);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [2:0] settled [4] = '{3'd0, 3'd1, 3'd3, 3'd5};
      logic [2:0] p;
      // sweep every code from every settled state, handshake low (R2-R6, R8)
      for (int i = 0; i < 4; i++) begin
         for (int c = 0; c < 8; c++) begin
            go_to(settled[i]);
            p = model_pend(settled[i], 3'(c));
            send(3'(c));
            chk(tag_of(settled[i], 3'(c)), stat, p);
            for (int k = 1; k < DWELL; k++) begin
               @(negedge clk);
               chk("R6", stat, p);
            end
            @(negedge clk);
            chk(tag_of(settled[i], 3'(c)), stat, model_final(p));
         end
      end

      // R7: handshake raised during the transient ends it after that cycle
      go_to(3'd3);
      send(3'd3);
      chk("R4", stat, 3'd6);
      hs = 1'b1;
      @(negedge clk);
      chk("R7", stat, 3'd5);
      hs = 1'b0;

      // R7: handshake already high gives a one-cycle transient
      hs = 1'b1;
      send(3'd4);
      chk("R5", stat, 3'd7);
      @(negedge clk);
      chk("R7", stat, 3'd3);
      hs = 1'b0;

      // R8: go sent during config-request is dropped, config still reached
      go_to(3'd0);
      send(3'd1);
      send(3'd2);
      chk("R8", stat, 3'd2);
      settle();
      chk("R8", stat, 3'd1);

      // R5: low-power to config needs wakeup then config
      go_to(3'd5);
      send(3'd4); settle();
      chk("R5", stat, 3'd3);
      send(3'd1); settle();
      chk("R2", stat, 3'd1);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule